// File: doc/BRIEF.md
# Serial Receiver Interrupt Mode Selector

This block turns receive-side events of a serial port into a single interrupt request for a CPU. A 2-bit mode field picks the source of the request. The four sources are: a new received word (the receive-ready flag rising), a multichannel block or frame boundary, a receive frame-sync pulse on the external pin, and a frame-sync error. The request is a one-cycle pulse in the port's internal clock domain.

The frame-sync pin is asynchronous to the internal clock, so it passes through a short synchronizer before its rising edge is detected. This source keeps working while the receiver is held in reset, so software can watch frame timing before it enables reception. The other three sources are held off while the receiver is in reset. The receive-ready and sync-error flags are mirrored to status outputs in every mode. The mode field chooses which event interrupts the CPU and does not change what the status outputs show.

Top module: `rx_irq_sel`

## Requirements
- R1: A synchronous active-high `rst` clears the mode field to 00 and holds `irq` low. The first cycle after reset also has `irq` low.
- R2: When `mode_wr` is high at a clock edge, `mode_wdata` is loaded into the mode field, and `mode_q` shows it from that edge on. The encodings are: 00 = ready edge, 01 = channel block / frame end, 10 = frame-sync pin, 11 = sync error.
- R3: In mode 00, `irq` is high for exactly one cycle, on the cycle after the cycle in which `rx_ready` is first sampled high after being low. Holding `rx_ready` high gives no further pulses.
- R4: In mode 01 with `mc_enable` high, a `chan_step` strobe whose `chan_idx` is a nonzero multiple of 16 (low 4 bits zero, upper bits nonzero) raises `irq` on the next cycle. A strobe with any other index raises nothing.
- R5: In mode 01 with `mc_enable` high, a `frame_end` strobe raises `irq` on the next cycle. If a block boundary and `frame_end` fall in the same cycle, the result is a single one-cycle pulse.
- R6: In mode 01 with `mc_enable` low, neither block boundaries nor `frame_end` raise `irq`.
- R7: In mode 10, a rising edge on `fsync_pin` raises a one-cycle `irq` three cycles after the first edge at which the pin is sampled high, whatever its width (at least one cycle). This also holds while `rx_in_reset` is high.
- R8: In mode 11, `sync_err` going from 0 to 1 raises `irq` for one cycle on the next cycle. While it stays high, no further pulses follow.
- R9: While `rx_in_reset` is high, modes 00, 01 and 11 raise no `irq`.
- R10: An event from a source other than the selected one never raises `irq`.
- R11: `ready_stat` follows `rx_ready` and `serr_stat` follows `sync_err` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal serial port clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | New mode value |
| mode_q | output | 2 | Current mode field |
| rx_ready | input | 1 | Receive-ready status flag |
| sync_err | input | 1 | Frame-sync error status flag |
| fsync_pin | input | 1 | Raw external receive frame-sync, asynchronous |
| rx_in_reset | input | 1 | Receiver held in reset |
| mc_enable | input | 1 | Multichannel selection mode enabled |
| chan_step | input | 1 | Channel-advance strobe from the receive logic |
| chan_idx | input | CHAN_W (7) | Index of the channel being entered on `chan_step` |
| frame_end | input | 1 | End-of-frame strobe from the receive logic |
| irq | output | 1 | One-cycle receive interrupt request |
| ready_stat | output | 1 | Mirror of `rx_ready` |
| serr_stat | output | 1 | Mirror of `sync_err` |

## Verification
The clocked properties assume that `rx_ready`, `sync_err` and the receive-logic strobes are synchronous to `clk`. They also assume that `fsync_pin`, once high, stays high for at least one whole cycle. The edge properties skip the first cycle after reset, because the edge detectors have just been cleared there. The stimulus changes every input only on the falling clock edge and holds each frame-sync pulse for one cycle or longer. It changes the mode only while every event input is low, so a mode switch never lands on a half-seen edge.

// File: rtl/rxint_pkg.sv
package rxint_pkg;

    typedef enum logic [1:0] {
        IRQ_SRC_READY = 2'b00,
        IRQ_SRC_CHBLK = 2'b01,
        IRQ_SRC_FSYNC = 2'b10,
        IRQ_SRC_SERR  = 2'b11
    } irq_src_e;

    typedef struct packed {
        logic ready_rise;
        logic chblk;
        logic fsync_rise;
        logic serr_rise;
    } irq_evt_t;

    // Only the frame-sync source keeps running while the receiver is held.
    function automatic logic pick_event(irq_src_e src, irq_evt_t ev, logic rx_held);
        logic hit;
        case (src)
            IRQ_SRC_READY: hit = ev.ready_rise & ~rx_held;
            IRQ_SRC_CHBLK: hit = ev.chblk      & ~rx_held;
            IRQ_SRC_FSYNC: hit = ev.fsync_rise;
            default:       hit = ev.serr_rise  & ~rx_held;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/rxint_rise.sv
module rxint_rise #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= d;
    end

    assign rise = d & ~prev_q;
endmodule

// File: rtl/rxint_sync_rise.sv
module rxint_sync_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b0;
                else if (i == 0) chain_q[i] <= async_in;
                else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rxint_chblk.sv
module rxint_chblk #(
    parameter int CHAN_W   = 7,
    parameter int BLOCK_CH = 16
) (
    input  logic              mc_enable,
    input  logic              chan_step,
    input  logic [CHAN_W-1:0] chan_idx,
    input  logic              frame_end,
    output logic              evt
);
    localparam int BLK_LSB = $clog2(BLOCK_CH);

    logic in_block_start;
    logic not_first_block;
    logic boundary;

    assign in_block_start  = (chan_idx[BLK_LSB-1:0] == '0);
    assign not_first_block = (chan_idx[CHAN_W-1:BLK_LSB] != '0);
    assign boundary        = chan_step & in_block_start & not_first_block;

    // A boundary and a frame end in the same cycle merge into one event.
    assign evt = mc_enable & (boundary | frame_end);
endmodule

// File: rtl/rx_irq_sel.sv
module rx_irq_sel
    import rxint_pkg::*;
#(
    parameter int CHAN_W      = 7,
    parameter int BLOCK_CH    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [1:0]        mode_wdata,
    output logic [1:0]        mode_q,
    input  logic              rx_ready,
    input  logic              sync_err,
    input  logic              fsync_pin,
    input  logic              rx_in_reset,
    input  logic              mc_enable,
    input  logic              chan_step,
    input  logic [CHAN_W-1:0] chan_idx,
    input  logic              frame_end,
    output logic              irq,
    output logic              ready_stat,
    output logic              serr_stat
);
    irq_src_e   mode_r;
    irq_evt_t   ev;
    logic [1:0] flag_rise;
    logic       irq_r;

    always_ff @(posedge clk) begin
        if (rst)          mode_r <= IRQ_SRC_READY;
        else if (mode_wr) mode_r <= irq_src_e'(mode_wdata);
    end

    rxint_rise #(.W(2)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .d    ({rx_ready, sync_err}),
        .rise (flag_rise)
    );

    rxint_sync_rise #(.STAGES(SYNC_STAGES)) u_fsync (
        .clk      (clk),
        .rst      (rst),
        .async_in (fsync_pin),
        .rise     (ev.fsync_rise)
    );

    rxint_chblk #(.CHAN_W(CHAN_W), .BLOCK_CH(BLOCK_CH)) u_chblk (
        .mc_enable (mc_enable),
        .chan_step (chan_step),
        .chan_idx  (chan_idx),
        .frame_end (frame_end),
        .evt       (ev.chblk)
    );

    assign ev.ready_rise = flag_rise[1];
    assign ev.serr_rise  = flag_rise[0];

    always_ff @(posedge clk) begin
        if (rst) irq_r <= 1'b0;
        else     irq_r <= pick_event(mode_r, ev, rx_in_reset);
    end

    assign irq        = irq_r;
    assign mode_q     = mode_r;
    assign ready_stat = rx_ready;
    assign serr_stat  = sync_err;
endmodule

// File: rtl/rx_irq_sel_chk.sv
module rx_irq_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_wr,
    input logic [1:0] mode_wdata,
    input logic [1:0] mode_q,
    input logic       rx_ready,
    input logic       sync_err,
    input logic       rx_in_reset,
    input logic       mc_enable,
    input logic       irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!irq && mode_q == 2'b00));

    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode_q == $past(mode_wdata)));

    // R3
    ready_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b00 && !rx_in_reset && rx_ready && !$past(rx_ready) && !$past(rst)) |=> irq);

    // R6
    mc_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b01 && !mc_enable) |=> !irq);

    // R8
    serr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b11 && sync_err && $past(sync_err) && !$past(rst)) |=> !irq);

    // R9
    held_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_in_reset && mode_q != 2'b10) |=> !irq);
endmodule

bind rx_irq_sel rx_irq_sel_chk chk_i (.*);

// File: tb/rx_irq_sel_tb_top.sv
module rx_irq_sel_tb_top;
    localparam int CHAN_W = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_wr = 1'b0;
    logic [1:0]        mode_wdata = 2'b00;
    logic [1:0]        mode_q;
    logic              rx_ready = 1'b0;
    logic              sync_err = 1'b0;
    logic              fsync_pin = 1'b0;
    logic              rx_in_reset = 1'b0;
    logic              mc_enable = 1'b0;
    logic              chan_step = 1'b0;
    logic [CHAN_W-1:0] chan_idx = '0;
    logic              frame_end = 1'b0;
    logic              irq;
    logic              ready_stat;
    logic              serr_stat;

    always #2.5 clk = ~clk;

    rx_irq_sel #(.CHAN_W(CHAN_W)) dut_i (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_q(mode_q), .rx_ready(rx_ready), .sync_err(sync_err),
        .fsync_pin(fsync_pin), .rx_in_reset(rx_in_reset), .mc_enable(mc_enable),
        .chan_step(chan_step), .chan_idx(chan_idx), .frame_end(frame_end),
        .irq(irq), .ready_stat(ready_stat), .serr_stat(serr_stat)
    );

    typedef struct {
        int    cyc;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   stray = 0;
    int   q0 = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int c, string r);
        exp_t e;
        e.cyc = c;
        e.req = r;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each observed pulse with the scoreboard queue.
    always @(negedge clk) begin
        if (!rst) begin
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                n_chk++;
                n_bad++;
                $display("FAIL %s: irq act=0 exp=1 at cycle %0d", exp_q[0].req, exp_q[0].cyc);
                void'(exp_q.pop_front());
            end
            if (irq) begin
                if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                    n_chk++;
                    void'(exp_q.pop_front());
                end else begin
                    n_chk++;
                    n_bad++;
                    stray++;
                    $display("FAIL R10: stray irq act=1 exp=0 at cycle %0d", cyc);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string r, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", r, act, exp);
        end
    endtask

    task automatic set_mode(logic [1:0] m);
        mode_wr    = 1'b1;
        mode_wdata = m;
        step();
        mode_wr    = 1'b0;
        chk(mode_q == m, "R2", int'(mode_q), int'(m));
    endtask

    task automatic quiet_end(int n, string r);
        repeat (n) step();
        chk(stray == q0, r, stray - q0, 0);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1: watchdog act=hung exp=finished");
            report();
        end
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        chk(irq == 1'b0, "R1", int'(irq), 0);
        chk(mode_q == 2'b00, "R1", int'(mode_q), 0);
        rst = 1'b0;
        step();
        chk(irq == 1'b0, "R1", int'(irq), 0);
        step();

        // R3: ready edge, held flag gives one pulse
        rx_ready = 1'b1;
        expect_at(cyc + 1, "R3");
        repeat (4) step();
        chk(ready_stat == 1'b1, "R11", int'(ready_stat), 1);
        rx_ready = 1'b0;
        repeat (2) step();
        rx_ready = 1'b1;
        expect_at(cyc + 1, "R3");
        step();
        rx_ready = 1'b0;
        repeat (2) step();

        // R4, R5: block boundaries and frame end
        set_mode(2'b01);
        mc_enable = 1'b1;
        chan_step = 1'b1;
        chan_idx  = 7'd15;
        step();
        chan_idx = 7'd16;
        expect_at(cyc + 1, "R4");
        step();
        chan_idx = 7'd17;
        step();
        chan_idx = 7'd32;
        expect_at(cyc + 1, "R4");
        step();
        chan_idx = 7'd0;
        step();
        chan_step = 1'b0;
        step();
        frame_end = 1'b1;
        expect_at(cyc + 1, "R5");
        step();
        frame_end = 1'b0;
        step();
        frame_end = 1'b1;
        chan_step = 1'b1;
        chan_idx  = 7'd48;
        expect_at(cyc + 1, "R5");
        step();
        frame_end = 1'b0;
        chan_step = 1'b0;
        repeat (2) step();

        // R6: multichannel mode off
        mc_enable = 1'b0;
        q0 = stray;
        chan_step = 1'b1;
        chan_idx  = 7'd16;
        step();
        chan_step = 1'b0;
        frame_end = 1'b1;
        step();
        frame_end = 1'b0;
        quiet_end(3, "R6");

        // R7: frame-sync pin, short, long and with receiver held
        set_mode(2'b10);
        fsync_pin = 1'b1;
        expect_at(cyc + 3, "R7");
        step();
        fsync_pin = 1'b0;
        repeat (4) step();
        fsync_pin = 1'b1;
        expect_at(cyc + 3, "R7");
        repeat (4) step();
        fsync_pin = 1'b0;
        repeat (4) step();
        rx_in_reset = 1'b1;
        fsync_pin = 1'b1;
        expect_at(cyc + 3, "R7");
        step();
        fsync_pin = 1'b0;
        repeat (4) step();
        rx_in_reset = 1'b0;

        // R10: other sources ignored in mode 10
        q0 = stray;
        rx_ready = 1'b1;
        step();
        rx_ready = 1'b0;
        sync_err = 1'b1;
        step();
        sync_err = 1'b0;
        quiet_end(4, "R10");

        // R8: sync error edge, no repeat while held
        set_mode(2'b11);
        sync_err = 1'b1;
        expect_at(cyc + 1, "R8");
        repeat (2) step();
        q0 = stray;
        repeat (5) step();
        chk(stray == q0, "R8", stray - q0, 0);
        chk(serr_stat == 1'b1, "R11", int'(serr_stat), 1);
        chk(ready_stat == 1'b0, "R11", int'(ready_stat), 0);
        sync_err = 1'b0;
        step();
        chk(serr_stat == 1'b0, "R11", int'(serr_stat), 0);

        // R9: receiver held gates modes 11, 00 and 01
        rx_in_reset = 1'b1;
        q0 = stray;
        sync_err = 1'b1;
        step();
        sync_err = 1'b0;
        quiet_end(3, "R9");
        set_mode(2'b00);
        q0 = stray;
        rx_ready = 1'b1;
        step();
        rx_ready = 1'b0;
        quiet_end(3, "R9");
        set_mode(2'b01);
        mc_enable = 1'b1;
        q0 = stray;
        frame_end = 1'b1;
        step();
        frame_end = 1'b0;
        quiet_end(3, "R9");
        rx_in_reset = 1'b0;
        mc_enable = 1'b0;

        // R10: frame-sync ignored in mode 11
        set_mode(2'b11);
        q0 = stray;
        fsync_pin = 1'b1;
        step();
        fsync_pin = 1'b0;
        quiet_end(6, "R10");

        repeat (4) step();
        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
        done = 1;
        report();
    end
endmodule